// File: doc/BRIEF.md
# Interrupt Dispatch and Halt Controller

This block sits next to a small 8-bit processor core and settles what happens at every instruction boundary. The core may fetch the next opcode, an interrupt service sequence may start, the core may be parked in a halted or stopped state, or it may be woken. The block holds the master interrupt enable, a 5-bit source enable register and a 5-bit pending flag register. Peripherals raise flag bits with one-clock pulses. The CPU writes both registers through a small write port.

A service sequence lasts five machine cycles of four clocks each. The first two are internal. The next two push the interrupted program counter onto the stack, high byte first, as one byte write per machine cycle. The last one hands the core the vector address of the chosen source. The core reports which control instruction just finished (enable, disable, return-from-interrupt, halt, stop) together with its boundary pulse. Stop mode is left only through the joypad wake lines, which are sampled once per machine cycle.

Top module: `intr_dispatch_ctrl`

## Requirements
- R1: After reset the master enable, the enable register and the flag register are all zero, `halted_o`, `stopped_o`, `bus_wr_o`, `pc_load_o` and `fetch_o` are low, and the controller accepts boundaries.
- R2: A boundary (`bound_i` high for one clock) that neither starts service nor enters halt or stop raises `fetch_o` for exactly the one clock that follows it.
- R3: Service starts at a boundary only when the master enable, as updated by that boundary, is set and (enable AND flag) is non-zero. Counting the clock after the starting edge as cycle 0, `fetch_o` stays low and the master enable reads zero from cycle 0. `bus_wr_o` is high in cycles 8 to 15. `pc_load_o` is high in cycle 19 only. `fetch_o` is high in cycle 20.
- R4: When several enabled flags are pending, the lowest bit index wins, and `pc_vec_o` during `pc_load_o` equals 0x40 + 8 × index.
- R5: The served source's flag bit is cleared at the end of the sequence (visible from cycle 20). Other flag bits are left as they were.
- R6: A boundary flagged as enable-interrupts leaves the master enable clear at that boundary and fetches normally. The master enable becomes set at the following boundary, and that boundary may start service.
- R7: A boundary flagged as disable-interrupts clears the master enable at once and cancels an enable still deferred from the previous boundary.
- R8: A boundary flagged as return-from-interrupt sets the master enable with no delay, so service may start at that same boundary.
- R9: A boundary flagged as halt raises `halted_o` from the next clock. While halted, a pending enabled flag ends the halt on the following edge. With the master enable clear, `fetch_o` pulses, no bus write occurs and the flag stays set. With it set, the service sequence of R3 runs instead.
- R10: A boundary flagged as stop raises `stopped_o`. In stop, the joypad lines are sampled only at the edge ending every fourth clock after entry (clocks 3, 7, 11, …). A non-zero sample leaves stop with `fetch_o` in the next clock. Pending interrupts do not end stop.
- R11: CPU writes use `reg_wr_sel_i` = 0 for the enable register and 1 for the flag register. A peripheral pulse on a flag bit sets it even when a CPU write of 0 or the service clear hits the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bound_i | input | 1 | One-clock pulse: instruction finished, decision point |
| op_ei_i | input | 1 | Finished instruction enables interrupts (deferred) |
| op_di_i | input | 1 | Finished instruction disables interrupts |
| op_reti_i | input | 1 | Finished instruction returns from interrupt |
| op_halt_i | input | 1 | Finished instruction requests halt |
| op_stop_i | input | 1 | Finished instruction requests stop |
| pc_i | input | ADDR_W | Address of the next instruction |
| sp_i | input | ADDR_W | Current stack pointer |
| reg_wr_en_i | input | 1 | CPU register write strobe |
| reg_wr_sel_i | input | 1 | 0 = enable register, 1 = flag register |
| reg_wdata_i | input | N_SRC | CPU write data |
| irq_pulse_i | input | N_SRC | Peripheral flag-set pulses |
| joy_i | input | JOY_W | Joypad wake lines |
| fetch_o | output | 1 | Core may fetch the next opcode |
| bus_wr_o | output | 1 | Stack push write request |
| bus_addr_o | output | ADDR_W | Push address |
| bus_wdata_o | output | DATA_W | Push data byte |
| pc_load_o | output | 1 | Core loads `pc_vec_o` into its program counter |
| pc_vec_o | output | ADDR_W | Service vector address |
| ime_o | output | 1 | Master interrupt enable |
| enable_o | output | N_SRC | Enable register |
| flag_o | output | N_SRC | Flag register |
| halted_o | output | 1 | Core is halted |
| stopped_o | output | 1 | Core is stopped |

## Verification
Setting a flag bit and clearing that same bit can fall in the same clock in two ways. A peripheral pulse can meet a CPU write of zero, or it can meet the service sequence's clear of the source it has just served. The bench provokes the first case by driving `irq_pulse_i` in the same clock as a flag-register write of zero. It provokes the second by pulsing the served source during the `pc_load_o` cycle. In both cases it judges the flag register on the following clock, where the pulsed bit must read one and every other bit must follow the write or the clear.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN  = 2'd0,
      SEQ_HALT = 2'd1,
      SEQ_STOP = 2'd2,
      SEQ_SVC  = 2'd3
   } seq_state_e;

   // machine-cycle layout of one service sequence
   localparam int unsigned SVC_MCYCLES = 5;
   localparam int unsigned PUSH_HI_MC  = 2;
   localparam int unsigned PUSH_LO_MC  = 3;

endpackage

// File: rtl/intr_ctrl_regs.sv
module intr_ctrl_regs #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic         wr_sel_i,
   input  logic [N-1:0] wdata_i,
   input  logic [N-1:0] pulse_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] enable_o,
   output logic [N-1:0] flag_o
);

   logic [N-1:0] flag_nx;

   // per-bit priority: peripheral set > CPU write > service clear > hold
   for (genvar b = 0; b < N; b++) begin : g_flag
      assign flag_nx[b] = pulse_i[b]             ? 1'b1 :
                          (wr_en_i && wr_sel_i)  ? wdata_i[b] :
                          clr_i[b]               ? 1'b0 : flag_o[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o   <= '0;
         enable_o <= '0;
      end else begin
         flag_o <= flag_nx;
         if (wr_en_i && !wr_sel_i) enable_o <= wdata_i;
      end
   end

endmodule

// File: rtl/intr_ctrl_prio.sv
module intr_ctrl_prio #(
   parameter int unsigned N = 5
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);

   for (genvar b = 0; b < N; b++) begin : g_grant
      if (b == 0) begin : g_top
         assign grant_o[b] = req_i[b];
      end else begin : g_low
         assign grant_o[b] = req_i[b] & ~(|req_i[b-1:0]);
      end
   end

endmodule

// File: rtl/intr_ctrl_ime.sv
module intr_ctrl_ime (
   input  logic clk,
   input  logic rst_n,
   input  logic bound_i,
   input  logic ei_i,
   input  logic di_i,
   input  logic reti_i,
   input  logic svc_start_i,
   output logic ime_nx_o,
   output logic ime_o,
   output logic pend_o
);

   // value the master enable takes at this boundary
   assign ime_nx_o = di_i ? 1'b0 : ((reti_i || pend_o) ? 1'b1 : ime_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ime_o  <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         if (svc_start_i)  ime_o <= 1'b0;
         else if (bound_i) ime_o <= ime_nx_o;
         if (bound_i)      pend_o <= ei_i & ~di_i;
      end
   end

endmodule

// File: rtl/intr_ctrl_seq.sv
module intr_ctrl_seq
   import intr_ctrl_pkg::*;
#(
   parameter int unsigned N          = 5,
   parameter int unsigned MCYC_TICKS = 4,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bound_i,
   input  logic              halt_i,
   input  logic              stop_i,
   input  logic              ime_nx_i,
   input  logic              ime_q_i,
   input  logic              pend_any_i,
   input  logic              joy_any_i,
   input  logic [N-1:0]      grant_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] sp_i,
   output logic              run_o,
   output logic              halted_o,
   output logic              stopped_o,
   output logic              fetch_o,
   output logic              svc_start_o,
   output logic              pc_load_o,
   output logic              bus_wr_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic [N-1:0]      sel_o
);

   localparam int unsigned SVC_TICKS = SVC_MCYCLES * MCYC_TICKS;
   localparam int unsigned CNT_W     = $clog2(SVC_TICKS);
   localparam logic [CNT_W-1:0] LAST     = CNT_W'(SVC_TICKS - 1);
   localparam logic [CNT_W-1:0] STEP_END = CNT_W'(MCYC_TICKS - 1);
   localparam logic [CNT_W-1:0] HI_FIRST = CNT_W'(PUSH_HI_MC * MCYC_TICKS);
   localparam logic [CNT_W-1:0] LO_FIRST = CNT_W'(PUSH_LO_MC * MCYC_TICKS);
   localparam logic [CNT_W-1:0] LO_END   = CNT_W'((PUSH_LO_MC + 1) * MCYC_TICKS);

   seq_state_e        st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] pc_q, sp_q;
   logic              take_run, take_halt, in_svc, push_hi;

   assign run_o     = (st_q == SEQ_RUN);
   assign halted_o  = (st_q == SEQ_HALT);
   assign stopped_o = (st_q == SEQ_STOP);
   assign in_svc    = (st_q == SEQ_SVC);

   assign take_run    = run_o & bound_i & ~halt_i & ~stop_i & ime_nx_i & pend_any_i;
   assign take_halt   = halted_o & pend_any_i & ime_q_i;
   assign svc_start_o = take_run | take_halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_RUN;
         cnt_q   <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         sel_o   <= '0;
         fetch_o <= 1'b0;
      end else begin
         fetch_o <= 1'b0;
         if (svc_start_o) begin
            pc_q  <= pc_i;
            sp_q  <= sp_i;
            sel_o <= grant_i;
         end
         case (st_q)
            SEQ_RUN: if (bound_i) begin
               if (stop_i) begin
                  st_q  <= SEQ_STOP;
                  cnt_q <= '0;
               end else if (halt_i) begin
                  st_q <= SEQ_HALT;
               end else if (take_run) begin
                  st_q  <= SEQ_SVC;
                  cnt_q <= '0;
               end else begin
                  fetch_o <= 1'b1;
               end
            end
            SEQ_HALT: if (pend_any_i) begin
               if (ime_q_i) begin
                  st_q  <= SEQ_SVC;
                  cnt_q <= '0;
               end else begin
                  st_q    <= SEQ_RUN;
                  fetch_o <= 1'b1;
               end
            end
            SEQ_STOP: begin
               if (cnt_q == STEP_END) begin
                  cnt_q <= '0;
                  if (joy_any_i) begin
                     st_q    <= SEQ_RUN;
                     fetch_o <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               if (cnt_q == LAST) begin
                  st_q    <= SEQ_RUN;
                  fetch_o <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         endcase
      end
   end

   assign push_hi     = (cnt_q < LO_FIRST);
   assign bus_wr_o    = in_svc && (cnt_q >= HI_FIRST) && (cnt_q < LO_END);
   assign bus_addr_o  = sp_q - (push_hi ? ADDR_W'(1) : ADDR_W'(2));
   assign bus_wdata_o = push_hi ? pc_q[ADDR_W-1 -: DATA_W] : pc_q[DATA_W-1:0];
   assign pc_load_o   = in_svc && (cnt_q == LAST);

endmodule

// File: rtl/intr_dispatch_ctrl.sv
module intr_dispatch_ctrl
   import intr_ctrl_pkg::*;
#(
   parameter int unsigned N_SRC      = 5,
   parameter int unsigned MCYC_TICKS = 4,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned JOY_W      = 4,
   parameter int unsigned VEC_BASE   = 'h40,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bound_i,
   input  logic              op_ei_i,
   input  logic              op_di_i,
   input  logic              op_reti_i,
   input  logic              op_halt_i,
   input  logic              op_stop_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] sp_i,
   input  logic              reg_wr_en_i,
   input  logic              reg_wr_sel_i,
   input  logic [N_SRC-1:0]  reg_wdata_i,
   input  logic [N_SRC-1:0]  irq_pulse_i,
   input  logic [JOY_W-1:0]  joy_i,
   output logic              fetch_o,
   output logic              bus_wr_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic              pc_load_o,
   output logic [ADDR_W-1:0] pc_vec_o,
   output logic              ime_o,
   output logic [N_SRC-1:0]  enable_o,
   output logic [N_SRC-1:0]  flag_o,
   output logic              halted_o,
   output logic              stopped_o
);

   if (N_SRC < 1 || N_SRC > 8) begin : g_bad_nsrc
      $error("N_SRC must lie in 1..8");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("ADDR_W must be twice DATA_W for a two-byte push");
   end
   if (MCYC_TICKS < 1) begin : g_bad_mcyc
      $error("MCYC_TICKS must be at least 1");
   end
   if (JOY_W < 1) begin : g_bad_joy
      $error("JOY_W must be at least 1");
   end

   logic [N_SRC-1:0] grant, sel, svc_clr;
   logic             pend_any, ime_nx, ei_pend, run_w, svc_start;

   assign pend_any = |(enable_o & flag_o);
   assign svc_clr  = pc_load_o ? sel : '0;

   intr_ctrl_regs #(.N(N_SRC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (reg_wr_en_i),
      .wr_sel_i (reg_wr_sel_i),
      .wdata_i  (reg_wdata_i),
      .pulse_i  (irq_pulse_i),
      .clr_i    (svc_clr),
      .enable_o (enable_o),
      .flag_o   (flag_o)
   );

   intr_ctrl_prio #(.N(N_SRC)) u_prio (
      .req_i   (enable_o & flag_o),
      .grant_o (grant)
   );

   intr_ctrl_ime u_ime (
      .clk         (clk),
      .rst_n       (rst_n),
      .bound_i     (bound_i & run_w),
      .ei_i        (op_ei_i),
      .di_i        (op_di_i),
      .reti_i      (op_reti_i),
      .svc_start_i (svc_start),
      .ime_nx_o    (ime_nx),
      .ime_o       (ime_o),
      .pend_o      (ei_pend)
   );

   intr_ctrl_seq #(
      .N(N_SRC), .MCYC_TICKS(MCYC_TICKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bound_i     (bound_i),
      .halt_i      (op_halt_i),
      .stop_i      (op_stop_i),
      .ime_nx_i    (ime_nx),
      .ime_q_i     (ime_o),
      .pend_any_i  (pend_any),
      .joy_any_i   (|joy_i),
      .grant_i     (grant),
      .pc_i        (pc_i),
      .sp_i        (sp_i),
      .run_o       (run_w),
      .halted_o    (halted_o),
      .stopped_o   (stopped_o),
      .fetch_o     (fetch_o),
      .svc_start_o (svc_start),
      .pc_load_o   (pc_load_o),
      .bus_wr_o    (bus_wr_o),
      .bus_addr_o  (bus_addr_o),
      .bus_wdata_o (bus_wdata_o),
      .sel_o       (sel)
   );

   always_comb begin
      pc_vec_o = ADDR_W'(VEC_BASE);
      for (int b = 0; b < int'(N_SRC); b++) begin
         if (sel[b]) pc_vec_o = ADDR_W'(VEC_BASE + b * VEC_STRIDE);
      end
   end

endmodule

// File: rtl/intr_dispatch_ctrl_chk.sv
module intr_dispatch_ctrl_chk #(
   parameter int unsigned N = 5
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bound_i,
   input logic         op_ei_i,
   input logic         op_di_i,
   input logic         op_reti_i,
   input logic [N-1:0] irq_pulse_i,
   input logic         fetch_o,
   input logic         bus_wr_o,
   input logic         pc_load_o,
   input logic         ime_o,
   input logic [N-1:0] flag_o,
   input logic         halted_o,
   input logic         stopped_o,
   input logic         run,
   input logic         ei_pend
);

   assert_push_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o |-> (!fetch_o && !ime_o));

   assert_load_then_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |=> fetch_o);

   assert_ei_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run && bound_i && op_ei_i && !ei_pend && !ime_o) |-> !ime_o);

   assert_di_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run && bound_i && op_di_i) |-> !ime_o);

   assert_reti_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run && bound_i && op_reti_i && !op_di_i) |-> (ime_o || !fetch_o));

   assert_modes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(halted_o && stopped_o));

   assert_halt_wake_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(halted_o) && !$past(ime_o)) |-> fetch_o);

   assert_stop_wake_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stopped_o) |-> fetch_o);

   assert_pulse_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(irq_pulse_i) & ~flag_o) == '0));

endmodule

bind intr_dispatch_ctrl intr_dispatch_ctrl_chk #(.N(N_SRC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bound_i     (bound_i),
   .op_ei_i     (op_ei_i),
   .op_di_i     (op_di_i),
   .op_reti_i   (op_reti_i),
   .irq_pulse_i (irq_pulse_i),
   .fetch_o     (fetch_o),
   .bus_wr_o    (bus_wr_o),
   .pc_load_o   (pc_load_o),
   .ime_o       (ime_o),
   .flag_o      (flag_o),
   .halted_o    (halted_o),
   .stopped_o   (stopped_o),
   .run         (run_w),
   .ei_pend     (ei_pend)
);

// File: tb/intr_dispatch_ctrl_test.sv
`timescale 1ns/1ps
module intr_dispatch_ctrl_test;

   localparam int NS = 5;
   localparam int AW = 16;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bound_i = 0, op_ei_i = 0, op_di_i = 0, op_reti_i = 0, op_halt_i = 0, op_stop_i = 0;
   logic [AW-1:0] pc_i = 16'h1234, sp_i = 16'hFFFE;
   logic reg_wr_en_i = 0, reg_wr_sel_i = 0;
   logic [NS-1:0] reg_wdata_i = '0, irq_pulse_i = '0;
   logic [3:0] joy_i = '0;
   logic fetch_o, bus_wr_o, pc_load_o, ime_o, halted_o, stopped_o;
   logic [AW-1:0] bus_addr_o, pc_vec_o;
   logic [DW-1:0] bus_wdata_o;
   logic [NS-1:0] enable_o, flag_o;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #4 clk = ~clk;

   intr_dispatch_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bound_i(bound_i), .op_ei_i(op_ei_i), .op_di_i(op_di_i),
      .op_reti_i(op_reti_i), .op_halt_i(op_halt_i), .op_stop_i(op_stop_i),
      .pc_i(pc_i), .sp_i(sp_i), .reg_wr_en_i(reg_wr_en_i), .reg_wr_sel_i(reg_wr_sel_i),
      .reg_wdata_i(reg_wdata_i), .irq_pulse_i(irq_pulse_i), .joy_i(joy_i),
      .fetch_o(fetch_o), .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .pc_load_o(pc_load_o), .pc_vec_o(pc_vec_o),
      .ime_o(ime_o), .enable_o(enable_o), .flag_o(flag_o),
      .halted_o(halted_o), .stopped_o(stopped_o)
   );

   typedef struct packed {
      logic [4:0]  en;
      logic [4:0]  fl;
      logic [15:0] vec;
      logic [4:0]  after;
   } prio_vec_t;

   localparam prio_vec_t TBL [6] = '{
      '{5'h1F, 5'h01, 16'h0040, 5'h00},
      '{5'h1F, 5'h12, 16'h0048, 5'h10},
      '{5'h1C, 5'h1F, 16'h0050, 5'h1B},
      '{5'h18, 5'h08, 16'h0058, 5'h00},
      '{5'h10, 5'h1F, 16'h0060, 5'h0F},
      '{5'h06, 5'h0C, 16'h0050, 5'h08}
   };

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic boundary(input bit ei, input bit di, input bit reti,
                           input bit halt, input bit stop);
      bound_i = 1; op_ei_i = ei; op_di_i = di; op_reti_i = reti;
      op_halt_i = halt; op_stop_i = stop;
      tick();
      bound_i = 0; op_ei_i = 0; op_di_i = 0; op_reti_i = 0;
      op_halt_i = 0; op_stop_i = 0;
   endtask

   task automatic wr_reg(input bit sel, input logic [4:0] d);
      reg_wr_en_i = 1; reg_wr_sel_i = sel; reg_wdata_i = d;
      tick();
      reg_wr_en_i = 0; reg_wr_sel_i = 0; reg_wdata_i = '0;
   endtask

   // called in cycle 0 of a service sequence
   task automatic svc_walk(input logic [15:0] vec, input logic [4:0] after,
                           input logic [4:0] end_pulse);
      logic [15:0] pc = pc_i;
      logic [15:0] sp = sp_i;
      chk("R3 no fetch at service start", fetch_o, 0);
      chk("R3 master enable cleared", ime_o, 0);
      for (int p = 0; p < 20; p++) begin
         if (p == 7)  chk("R3 no push before cycle 8", bus_wr_o, 0);
         if (p == 8) begin
            chk("R3 high push strobe", bus_wr_o, 1);
            chk("R3 high push address", bus_addr_o, sp - 16'd1);
            chk("R3 high push data", bus_wdata_o, pc[15:8]);
         end
         if (p == 12) begin
            chk("R3 low push strobe", bus_wr_o, 1);
            chk("R3 low push address", bus_addr_o, sp - 16'd2);
            chk("R3 low push data", bus_wdata_o, pc[7:0]);
         end
         if (p == 16) chk("R3 push ended", bus_wr_o, 0);
         if (p == 18) chk("R3 no early load", pc_load_o, 0);
         if (p == 19) begin
            chk("R3 vector load strobe", pc_load_o, 1);
            chk("R4 vector address", pc_vec_o, vec);
            irq_pulse_i = end_pulse;
         end
         tick();
      end
      irq_pulse_i = '0;
      chk("R3 fetch after service", fetch_o, 1);
      chk("R3 load strobe dropped", pc_load_o, 0);
      chk("R5 R11 flags after service", flag_o, after);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 ime", ime_o, 0);
      chk("R1 enable", enable_o, 0);
      chk("R1 flag", flag_o, 0);
      chk("R1 halted", halted_o, 0);
      chk("R1 stopped", stopped_o, 0);
      chk("R1 bus write", bus_wr_o, 0);
      chk("R1 load", pc_load_o, 0);
      chk("R1 fetch", fetch_o, 0);

      // R2 plain boundary
      boundary(0, 0, 0, 0, 0);
      chk("R2 fetch pulse", fetch_o, 1);
      tick();
      chk("R2 fetch one clock", fetch_o, 0);

      // R3 pending but master enable clear
      wr_reg(0, 5'h01);
      wr_reg(1, 5'h01);
      boundary(0, 0, 0, 0, 0);
      chk("R3 no service with ime clear", fetch_o, 1);
      chk("R3 flag kept", flag_o, 5'h01);

      // R6 deferred enable
      boundary(1, 0, 0, 0, 0);
      chk("R6 fetch at EI boundary", fetch_o, 1);
      chk("R6 ime still clear", ime_o, 0);
      boundary(0, 0, 0, 0, 0);
      svc_walk(16'h0040, 5'h00, 5'h00);

      // R7 DI cancels deferred enable
      wr_reg(1, 5'h01);
      boundary(1, 0, 0, 0, 0);
      boundary(0, 1, 0, 0, 0);
      chk("R7 ime clear after DI", ime_o, 0);
      boundary(0, 0, 0, 0, 0);
      chk("R7 fetch, no service", fetch_o, 1);
      chk("R7 ime stays clear", ime_o, 0);
      wr_reg(1, 5'h00);
      boundary(0, 0, 1, 0, 0);
      chk("R8 ime set by RETI", ime_o, 1);
      chk("R8 fetch with nothing pending", fetch_o, 1);
      boundary(0, 1, 0, 0, 0);
      chk("R7 DI clears at once", ime_o, 0);

      // R3 enable set but no overlap
      wr_reg(1, 5'h02);
      boundary(0, 0, 1, 0, 0);
      boundary(0, 0, 0, 0, 0);
      chk("R3 no service without overlap", fetch_o, 1);
      chk("R3 ime kept", ime_o, 1);
      boundary(0, 1, 0, 0, 0);

      // R4 R5 R8 priority table
      for (int k = 0; k < 6; k++) begin
         wr_reg(0, TBL[k].en);
         wr_reg(1, TBL[k].fl);
         chk("R8 ime clear before RETI", ime_o, 0);
         pc_i = 16'h1000 + 16'(k * 'h111);
         sp_i = 16'hC000 + 16'(k * 2);
         boundary(0, 0, 1, 0, 0);
         svc_walk(TBL[k].vec, TBL[k].after, 5'h00);
      end

      // R9 halt with ime clear
      wr_reg(0, 5'h01);
      wr_reg(1, 5'h00);
      boundary(0, 0, 0, 1, 0);
      chk("R9 halted", halted_o, 1);
      chk("R9 no fetch on halt", fetch_o, 0);
      repeat (3) tick();
      chk("R9 still halted", halted_o, 1);
      irq_pulse_i = 5'h01;
      tick();
      irq_pulse_i = '0;
      chk("R9 halted until next edge", halted_o, 1);
      tick();
      chk("R9 woke", halted_o, 0);
      chk("R9 fetch on wake", fetch_o, 1);
      chk("R9 no push on wake", bus_wr_o, 0);
      chk("R9 flag left set", flag_o, 5'h01);

      // R9 halt with ime set
      wr_reg(1, 5'h00);
      wr_reg(0, 5'h08);
      pc_i = 16'h2468; sp_i = 16'hDFF0;
      boundary(0, 0, 1, 0, 0);
      boundary(0, 0, 0, 1, 0);
      chk("R9 halted with ime", halted_o, 1);
      tick();
      irq_pulse_i = 5'h08;
      tick();
      irq_pulse_i = '0;
      tick();
      chk("R9 left halt into service", halted_o, 0);
      svc_walk(16'h0058, 5'h00, 5'h00);

      // R10 stop
      wr_reg(0, 5'h01);
      boundary(0, 0, 0, 0, 1);
      chk("R10 stopped", stopped_o, 1);
      irq_pulse_i = 5'h01;
      tick();
      irq_pulse_i = '0;
      joy_i = 4'b0001;
      tick();
      joy_i = '0;
      chk("R10 joypad off-step ignored", stopped_o, 1);
      repeat (5) tick();
      chk("R10 interrupt does not wake", stopped_o, 1);
      chk("R10 no fetch while stopped", fetch_o, 0);
      joy_i = 4'b0100;
      tick();
      joy_i = '0;
      chk("R10 joypad wakes", stopped_o, 0);
      chk("R10 fetch after stop", fetch_o, 1);

      // R11 peripheral set against CPU clear
      wr_reg(1, 5'h11);
      reg_wr_en_i = 1; reg_wr_sel_i = 1; reg_wdata_i = 5'h00; irq_pulse_i = 5'h04;
      tick();
      reg_wr_en_i = 0; reg_wr_sel_i = 0; irq_pulse_i = '0;
      chk("R11 pulse beats CPU clear", flag_o, 5'h04);

      // R11 peripheral set against service clear
      wr_reg(0, 5'h02);
      wr_reg(1, 5'h02);
      boundary(0, 0, 1, 0, 0);
      svc_walk(16'h0048, 5'h02, 5'h02);

      done = 1;
      summary();
      $finish;
   end

endmodule